// File: doc/BRIEF.md
# Over-Temperature Alert Controller

This block watches the stream of finished temperature conversions and decides when a thermal alert output should be raised and when it should drop. Each result is a 16-bit word that carries a 12-bit two's-complement temperature in its upper bits, at 0.0625 °C per step. The four lowest bits are always zero and play no part in any decision. Each result is compared, as a signed number, against an over-temperature limit and a lower hysteresis limit held in the same format.

Configuration inputs choose how the alert behaves. In comparator mode the output follows the thermal state with hysteresis. In interrupt mode the output latches, is cleared by any register read, and arms again only after the temperature has fallen below the hysteresis limit. A fault count of 1, 2, 4 or 6 consecutive over-limit conversions guards against noise. A polarity bit selects whether the output is active high or active low. A bus-alert option lets an alert-response acknowledgement clear the latched alert. A shutdown input stops conversions from being taken.

The output is a logic level meant to drive an open-drain pad. A separate status bit tells the serial-bus block whether the latest result is at or above the over-temperature limit.

Top module: `ota_alert_ctrl`

## Requirements
- R1: `cfg_int_mode` selects the behaviour: 0 is comparator mode, 1 is interrupt mode. After reset the alert is inactive, the counter is empty, and interrupt mode starts armed.
- R2: `alert_pin` equals the internal alert state when `cfg_act_high` is 1 and its inverse when `cfg_act_high` is 0, so after reset the pin sits at the inverse of `cfg_act_high`.
- R3: `cfg_fault_code` sets how many consecutive over-limit conversions are needed before the alert asserts: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6. The pin changes in the cycle after the clock edge that accepts the last of those conversions.
- R4: In comparator mode the alert asserts only after over-limit conversions (result >= over limit). It then stays asserted until a conversion falls strictly below the hysteresis limit, which deasserts it on that conversion. Reads have no effect in this mode.
- R5: In interrupt mode a pulse on `reg_read` clears the alert. Once the alert has asserted, it cannot assert again until a conversion below the hysteresis limit, accepted while the alert is inactive, has re-armed it. A new run of over-limit conversions then asserts it again. A clear in the same cycle as an assertion wins.
- R6: While `shutdown` is high, no conversion is accepted. In interrupt mode shutdown clears the alert. In comparator mode shutdown leaves the alert unchanged.
- R7: `ara_served` clears the alert only when `cfg_smb_alert` is 1 and interrupt mode is selected. Otherwise it has no effect.
- R8: Comparisons use bits 15:4 as a signed number. Bits 3:0 of the result and of both limits are ignored.
- R9: `over_status` is updated on each accepted conversion to 1 when the result is at or above the over limit, and to 0 otherwise. It holds between conversions and is 0 after reset.
- R10: An accepted conversion that does not meet the over-limit condition empties the fault counter, so the count must start again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is present |
| res_temp | input | 16 | Conversion result, signed code in bits 15:4 |
| lim_over | input | 16 | Over-temperature limit, same format |
| lim_hyst | input | 16 | Hysteresis limit, same format |
| cfg_int_mode | input | 1 | 0 comparator mode, 1 interrupt mode |
| cfg_act_high | input | 1 | 1 active-high output, 0 active-low output |
| cfg_fault_code | input | 2 | Consecutive fault count code (1/2/4/6) |
| cfg_smb_alert | input | 1 | Enables clearing by the alert-response acknowledgement |
| reg_read | input | 1 | One-cycle strobe: a register was read over the bus |
| ara_served | input | 1 | One-cycle strobe: the alert response address was served |
| shutdown | input | 1 | Shutdown request, level |
| alert_pin | output | 1 | Alert level for the open-drain pad |
| over_status | output | 1 | Latest result at or above the over limit |

## Verification
The hardest state to reach from the ports is a second assertion in interrupt mode with the largest fault count. To get there, the alert must first assert after six uninterrupted over-limit results. It must then be cleared by a read and re-armed by a below-hysteresis result accepted while inactive. Only after that can a fresh run of six results assert it again. The sweep drives a repeating 16-step temperature pattern that contains a seven-long over-limit run, a short two-long run, hysteresis-band and below-hysteresis values, reads and acknowledgements at fixed steps, and gaps in the valid strobe. The pattern runs for every mode, polarity, fault code and alert-option combination, so each of these transitions occurs many times. Directed sequences then hit the exact fault-count edge, equality with the limits, negative limits, and nonzero low nibbles.

// File: rtl/ota_pkg.sv
package ota_pkg;

  typedef enum logic {
    MODE_CMP = 1'b0,
    MODE_INT = 1'b1
  } alert_mode_e;

  localparam int MAX_FAULTS = 6;

  // consecutive conversions needed for each fault-count code
  function automatic logic [2:0] fault_target(input logic [1:0] code);
    logic [2:0] n;
    case (code)
      2'b00:   n = 3'd1;
      2'b01:   n = 3'd2;
      2'b10:   n = 3'd4;
      default: n = 3'd6;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ota_limit_compare.sv
module ota_limit_compare #(
  parameter int TW = 16,
  parameter int FW = 4
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  output logic          at_or_above,
  output logic          below_hyst
);
  localparam int CODE_W = TW - FW;

  function automatic logic signed [CODE_W-1:0] code_of(input logic [TW-1:0] w);
    return signed'(w[TW-1:FW]);
  endfunction

  function automatic logic sge(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return code_of(a) >= code_of(b);
  endfunction

  function automatic logic slt(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return code_of(a) < code_of(b);
  endfunction

  assign at_or_above = sge(temp, lim_hi);
  assign below_hyst  = slt(temp, lim_lo);

  generate
    if (FW > 0) begin : g_frac
      logic unused_frac;
      assign unused_frac = ^{temp[FW-1:0], lim_hi[FW-1:0], lim_lo[FW-1:0]};
    end
  endgenerate

endmodule

// File: rtl/ota_fault_queue.sv
module ota_fault_queue #(
  parameter int CNT_W = 3,
  parameter int MAX_F = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             hit,
  input  logic             flush,
  input  logic [CNT_W-1:0] target,
  output logic             reached
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] c);
    return {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  assign cnt_inc = bump(cnt_q);
  assign reached = step && hit && !flush && (cnt_inc >= {1'b0, target});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (flush || reached || (step && !hit)) cnt_q <= '0;
    else if (step)                          cnt_q <= cnt_inc[CNT_W-1:0];
  end

  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_F))
    else $error("fault counter past largest count");

  assert_miss_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit) |=> (cnt_q == '0))
    else $error("miss did not empty fault counter");

endmodule

// File: rtl/ota_alert_state.sv
module ota_alert_state
  import ota_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  alert_mode_e mode,
  input  logic        smb_en,
  input  logic        conv,
  input  logic        under,
  input  logic        reached,
  input  logic        rd,
  input  logic        ara,
  input  logic        sd,
  output logic        active,
  output logic        armed
);
  logic active_q, armed_q, active_d, armed_d;
  logic clr_int, cmp_release, rearm;

  assign clr_int     = (mode == MODE_INT) && (rd || sd || (smb_en && ara));
  assign cmp_release = (mode == MODE_CMP) && conv && active_q && under;
  assign rearm       = (mode == MODE_INT) && conv && !armed_q && !active_q && under;

  always_comb begin
    active_d = active_q;
    armed_d  = armed_q;
    if (cmp_release) active_d = 1'b0;
    else if (reached) active_d = 1'b1;
    if (clr_int) active_d = 1'b0;
    if (mode == MODE_INT) begin
      if (reached)    armed_d = 1'b0;
      else if (rearm) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b1;
    end else begin
      active_q <= active_d;
      armed_q  <= armed_d;
    end
  end

  assign active = active_q;
  assign armed  = armed_q;

  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CMP && active_q && !(conv && under)) |=> active_q)
    else $error("comparator alert dropped without hysteresis crossing");

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INT && rd) |=> !active_q)
    else $error("read did not clear interrupt alert");

  assert_sd_clears_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INT && sd) |=> !active_q)
    else $error("shutdown did not clear interrupt alert");

  assert_sd_holds_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CMP && sd) |=> (active_q == $past(active_q)))
    else $error("shutdown changed comparator alert");

  assert_ara_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INT && smb_en && ara) |=> !active_q)
    else $error("alert response did not clear alert");

  assert_no_rearm_while_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INT && active_q) |=> !$rose(armed_q))
    else $error("interrupt re-armed while alert active");

endmodule

// File: rtl/ota_alert_ctrl.sv
module ota_alert_ctrl
  import ota_pkg::*;
#(
  parameter int TW    = 16,
  parameter int FW    = 4,
  parameter int CNT_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [TW-1:0] res_temp,
  input  logic [TW-1:0] lim_over,
  input  logic [TW-1:0] lim_hyst,
  input  logic          cfg_int_mode,
  input  logic          cfg_act_high,
  input  logic [1:0]    cfg_fault_code,
  input  logic          cfg_smb_alert,
  input  logic          reg_read,
  input  logic          ara_served,
  input  logic          shutdown,
  output logic          alert_pin,
  output logic          over_status
);
  alert_mode_e      mode_e;
  logic             conv_acc;
  logic             over_w, under_w;
  logic             active_w, armed_w, reached_w, flush_w;
  logic [CNT_W-1:0] target_w;
  logic             status_q;

  assign mode_e   = alert_mode_e'(cfg_int_mode);
  assign conv_acc = res_valid && !shutdown;
  assign target_w = CNT_W'(fault_target(cfg_fault_code));
  assign flush_w  = active_w || (mode_e == MODE_INT && !armed_w);

  ota_limit_compare #(.TW(TW), .FW(FW)) u_cmp (
    .temp        (res_temp),
    .lim_hi      (lim_over),
    .lim_lo      (lim_hyst),
    .at_or_above (over_w),
    .below_hyst  (under_w)
  );

  ota_fault_queue #(.CNT_W(CNT_W), .MAX_F(MAX_FAULTS)) u_fq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (conv_acc),
    .hit     (over_w),
    .flush   (flush_w),
    .target  (target_w),
    .reached (reached_w)
  );

  ota_alert_state u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_e),
    .smb_en  (cfg_smb_alert),
    .conv    (conv_acc),
    .under   (under_w),
    .reached (reached_w),
    .rd      (reg_read),
    .ara     (ara_served),
    .sd      (shutdown),
    .active  (active_w),
    .armed   (armed_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= 1'b0;
    else if (conv_acc) status_q <= over_w;
  end

  assign over_status = status_q;
  assign alert_pin   = cfg_act_high ? active_w : !active_w;

  assert_rise_needs_over_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_w && !(conv_acc && over_w)) |=> !active_w)
    else $error("alert rose without an over-limit conversion");

  assert_status_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_acc |=> (over_status == $past(over_w)))
    else $error("status does not follow latest conversion");

  assert_status_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_acc |=> $stable(over_status))
    else $error("status moved without a conversion");

endmodule

// File: tb/sim_ota_alert_ctrl.sv
`timescale 1ns/1ps
module sim_ota_alert_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [15:0] t = '0, hi = 16'h5000, hy = 16'h4B00;
  logic        md = 1'b0, pl = 1'b0, sm = 1'b0;
  logic [1:0]  fc = 2'b00;
  logic        rd = 1'b0, ara = 1'b0, sd = 1'b0;
  logic        pin, stat;

  int nvec = 0, nmis = 0;
  bit m_act, m_arm, m_lim;
  int m_cnt;

  always #4 clk = ~clk;

  ota_alert_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(v), .res_temp(t),
    .lim_over(hi), .lim_hyst(hy), .cfg_int_mode(md), .cfg_act_high(pl),
    .cfg_fault_code(fc), .cfg_smb_alert(sm), .reg_read(rd),
    .ara_served(ara), .shutdown(sd), .alert_pin(pin), .over_status(stat)
  );

  function automatic int sc(input logic [15:0] w);
    int x;
    x = int'(w) >>> 4;
    if (x >= 2048) x = x - 4096;
    return x;
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    nvec++;
    if (got !== exp) begin
      nmis++;
      $display("FAIL %s %s: got %0b expected %0b (md=%0b pl=%0b fc=%0d sm=%0b)",
               tag, what, got, exp, md, pl, fc, sm);
    end
  endtask

  task automatic model(input bit cv, input logic [15:0] tw, input bit r, input bit a, input bit s);
    bit conv, ov, un;
    int need;
    conv = cv && !s;
    ov   = sc(tw) >= sc(hi);
    un   = sc(tw) <  sc(hy);
    need = (fc == 0) ? 1 : 2 * int'(fc);
    if (conv) m_lim = ov;
    if (!md) begin
      if (conv) begin
        if (m_act) begin
          if (un) m_act = 0;
          m_cnt = 0;
        end else if (ov) begin
          m_cnt++;
          if (m_cnt >= need) begin m_act = 1; m_cnt = 0; end
        end else m_cnt = 0;
      end
    end else begin
      if (conv) begin
        if (m_act || !m_arm) begin
          m_cnt = 0;
          if (!m_act && !m_arm && un) m_arm = 1;
        end else if (ov) begin
          m_cnt++;
          if (m_cnt >= need) begin m_act = 1; m_arm = 0; m_cnt = 0; end
        end else m_cnt = 0;
      end
      if (r || s || (sm && a)) m_act = 0;
    end
  endtask

  task automatic cyc(input bit cv, input logic [15:0] tw, input bit r, input bit a,
                     input bit s, input string tag);
    v = cv; t = tw; rd = r; ara = a; sd = s;
    model(cv, tw, r, a, s);
    @(posedge clk); #2;
    v = 0; rd = 0; ara = 0; sd = 0;
    check(tag, "alert_pin", pin, pl ? m_act : !m_act);
    check("R9", "over_status", stat, m_lim);
  endtask

  task automatic do_reset();
    rst_n = 0; v = 0; rd = 0; ara = 0; sd = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    m_act = 0; m_arm = 1; m_cnt = 0; m_lim = 0;
    @(posedge clk); #2;
  endtask

  function automatic logic [11:0] pat_code(input int i);
    int k;
    k = i % 16;
    if (k < 7)       return (i % 2) ? 12'h503 : 12'h500;
    else if (k == 7) return 12'h4B0;
    else if (k < 10) return (k == 8) ? 12'h4AF : 12'hC90;
    else if (k < 12) return 12'h500;
    else if (k == 12) return 12'h4B0;
    else             return 12'h4AF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    // R2 reset level, R4 comparator behaviour
    md = 0; pl = 0; fc = 0; sm = 0; hi = 16'h5000; hy = 16'h4B00;
    do_reset();
    check("R2", "reset pin", pin, 1'b1);
    check("R9", "reset status", stat, 1'b0);
    cyc(1, 16'h5000, 0, 0, 0, "R4");   // equal to limit asserts
    cyc(1, 16'h4B00, 1, 0, 0, "R4");   // in band, read ignored
    cyc(1, 16'h4AF0, 0, 0, 0, "R4");   // below hysteresis releases
    pl = 1; #1;
    check("R2", "active-high idle", pin, 1'b0);

    // R3 fault count, R10 miss empties counter
    fc = 2'b01; do_reset();
    cyc(1, 16'h5100, 0, 0, 0, "R3");
    cyc(1, 16'h4C00, 0, 0, 0, "R10");
    cyc(1, 16'h5100, 0, 0, 0, "R10");
    cyc(1, 16'h5100, 0, 0, 0, "R3");
    fc = 2'b11; do_reset();
    for (int i = 0; i < 5; i++) cyc(1, 16'h6000, 0, 0, 0, "R3");
    cyc(0, 16'h6000, 0, 0, 0, "R3");
    cyc(1, 16'h6000, 0, 0, 0, "R3");

    // R5 interrupt latch, read clear, re-arm
    md = 1; fc = 0; do_reset();
    cyc(1, 16'h5000, 0, 0, 0, "R5");
    cyc(1, 16'h5000, 1, 0, 0, "R5");
    cyc(1, 16'h5800, 0, 0, 0, "R5");
    cyc(1, 16'h4A00, 0, 0, 0, "R5");
    cyc(1, 16'h5800, 0, 0, 0, "R5");

    // R6 shutdown in both modes
    do_reset();
    cyc(1, 16'h5800, 0, 0, 0, "R6");
    cyc(1, 16'h5800, 0, 0, 1, "R6");
    md = 0; do_reset();
    cyc(1, 16'h5800, 0, 0, 0, "R6");
    cyc(1, 16'h1000, 0, 0, 1, "R6");
    cyc(1, 16'h1000, 0, 0, 1, "R6");
    cyc(1, 16'h1000, 0, 0, 0, "R6");

    // R7 acknowledgement clears only in interrupt mode with option set
    md = 1; sm = 1; do_reset();
    cyc(1, 16'h5800, 0, 0, 0, "R7");
    cyc(0, 16'h5800, 0, 1, 0, "R7");
    sm = 0; do_reset();
    cyc(1, 16'h5800, 0, 0, 0, "R7");
    cyc(0, 16'h5800, 0, 1, 0, "R7");
    md = 0; sm = 1; do_reset();
    cyc(1, 16'h5800, 0, 0, 0, "R7");
    cyc(0, 16'h5800, 0, 1, 0, "R7");

    // R8 low nibble ignored, signed compare
    sm = 0; do_reset();
    cyc(1, 16'h4FFF, 0, 0, 0, "R8");
    cyc(1, 16'h500F, 0, 0, 0, "R8");
    hi = 16'hFF0A; hy = 16'hFE05; do_reset();
    cyc(1, 16'hF000, 0, 0, 0, "R8");
    cyc(1, 16'h0000, 0, 0, 0, "R8");

    // R1 sweep over every configuration
    hi = 16'h5000; hy = 16'h4B00;
    for (int c = 0; c < 32; c++) begin
      md = c[0]; pl = c[1]; fc = c[3:2]; sm = c[4];
      do_reset();
      for (int i = 0; i < 64; i++) begin
        int k;
        k = i % 16;
        cyc((i % 5) != 4, {pat_code(i), 4'(i)}, (k == 9) || (k == 13), k == 3, 0,
            md ? "R5" : "R1");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule